// File: doc/BRIEF.md
# Frame-Transfer CCD Frame Sequencer

This block drives the frame-level timing of a frame-transfer CCD. Each frame opens with a frame shift: a burst of line transfers that moves the whole image area into the light-shielded storage area. During the burst the four image-area phases and the four storage-area phases toggle in lockstep. Each transfer lasts one slow transfer period. Within that period every phase is high for five eighths of the time, and the phases are spaced a quarter period apart.

When the burst ends, the block steps through the readout line times of the frame. For each line it hands a one-cycle start strobe to the horizontal line generator and waits for that generator's end-of-line indication. It raises a clamp flag on a parameterised band of optical black lines. On one programmable line it inserts a charge-reset pulse that flushes the collected charge, which shortens the effective exposure. A shutter line of zero turns shuttering off. After the last line time of the frame, the next burst begins at once.

Top module: `frame_shift_seq`

## Requirements
- R1: On reset release the burst starts immediately: lineStart, crPulse and blkClamp are low, and the image clocks show transfer position 0.
- R2: stgClk always equals imgClk, and both are all low outside the burst.
- R3: The burst is SHIFT_LINES transfers of PERIOD cycles each. Counting cycles from reset release as 0, the first lineStart is high in cycle SHIFT_LINES*PERIOD.
- R4: During the burst, phase bit i (bit 0 to bit 3) is high when ((c - i*PERIOD/4) mod PERIOD) < HIGH_CYCLES, where c is the cycle position within the current transfer (defaults 48 and 30).
- R5: lineStart is a one-cycle pulse, high in the cycle after the cycle in which lineDone is sampled high during readout.
- R6: lineDone is ignored during the burst. The burst neither shortens nor emits lineStart.
- R7: A lineDone on readout line FRAME_LINES-1 (lines numbered from 0) starts a new burst in the next cycle, with no lineStart.
- R8: When shutterLine is nonzero and equals the line index, crPulse is high for CR_CYCLES cycles, starting in that line's lineStart cycle (default 45 cycles, 1.25 us at 36 MHz).
- R9: With shutterLine equal to 0, crPulse stays low for the whole frame.
- R10: blkClamp is high from lineStart through the lineDone cycle of lines BLK_FIRST to BLK_LAST, and low on every other line and during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| shutterLine | input | LINE_W | Line that receives the charge-reset pulse; 0 turns shuttering off |
| lineDone | input | 1 | End-of-line indication from the line generator |
| lineStart | output | 1 | One-cycle start strobe to the line generator |
| crPulse | output | 1 | Charge-reset pulse for the image clock drivers |
| blkClamp | output | 1 | Black-level clamp flag |
| imgClk | output | 4 | Image-area phase clocks |
| stgClk | output | 4 | Storage-area phase clocks |

## Verification
Phase clocks are combinational from the transfer counter. They are compared in every cycle of a burst against the formula, using the bench's own cycle index counted from reset release. A lineStart is due exactly one cycle after the lineDone cycle, or SHIFT_LINES*PERIOD cycles after a burst begins. The driver queues that cycle number, and the monitor compares it against the cycle in which the strobe is seen. The clamp flag is checked in the lineStart cycle of each line. The charge-reset pulse is counted over a window that opens in the lineStart cycle and is longer than CR_CYCLES.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int NUM_PHASES = 4;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftRun;  // burst in progress: advance transfer counters
    logic crLoad;    // arm the charge-reset pulse for the next line
  } seqStrobe_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int FRAME_LINES = 1250,
  parameter int LINE_W      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftDone,
  input  logic              lineDone,
  input  logic [LINE_W-1:0] shutterLine,
  output seqStrobe_t        strobe,
  output logic              lineStart,
  output logic [LINE_W-1:0] lineIdx,
  output logic              busy
);
  logic              frameEnd;
  logic              startNext;
  logic [LINE_W-1:0] nextIdx;

  always_comb begin
    frameEnd  = !busy && lineDone && (lineIdx == LINE_W'(FRAME_LINES - 1));
    startNext = (busy && shiftDone) || (!busy && lineDone && !frameEnd);
    nextIdx   = busy ? '0 : lineIdx + 1'b1;
    strobe.shiftRun = busy;
    strobe.crLoad   = startNext && (shutterLine != '0) && (nextIdx == shutterLine);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b1;
      lineIdx   <= '0;
      lineStart <= 1'b0;
    end else begin
      lineStart <= startNext;
      if (startNext) lineIdx <= nextIdx;
      if (busy && shiftDone) busy <= 1'b0;
      else if (frameEnd)     busy <= 1'b1;
    end
  end
endmodule

// File: rtl/fts_dp.sv
module fts_dp
  import fts_pkg::*;
#(
  parameter int PERIOD      = 48,
  parameter int HIGH_CYCLES = 30,
  parameter int SHIFT_LINES = 1048,
  parameter int CR_CYCLES   = 45,
  parameter int BLK_FIRST   = 5,
  parameter int BLK_LAST    = 12,
  parameter int LINE_W      = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [LINE_W-1:0]     lineIdx,
  output logic                  shiftDone,
  output logic                  crPulse,
  output logic                  blkClamp,
  output logic [NUM_PHASES-1:0] imgClk,
  output logic [NUM_PHASES-1:0] stgClk
);
  localparam int PH_W = $clog2(PERIOD);
  localparam int XF_W = $clog2(SHIFT_LINES + 1);
  localparam int CR_W = $clog2(CR_CYCLES + 1);

  logic [PH_W-1:0]       phaseCnt;
  logic [XF_W-1:0]       xferCnt;
  logic [CR_W-1:0]       crCnt;
  logic [NUM_PHASES-1:0] phaseHigh;

  assign shiftDone = strobe.shiftRun && (phaseCnt == PH_W'(PERIOD - 1))
                     && (xferCnt == XF_W'(SHIFT_LINES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      xferCnt  <= '0;
    end else if (strobe.shiftRun) begin
      if (phaseCnt == PH_W'(PERIOD - 1)) begin
        phaseCnt <= '0;
        xferCnt  <= shiftDone ? '0 : xferCnt + 1'b1;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // phase i lags phase 0 by i quarter periods
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    localparam int OFF = i * PERIOD / NUM_PHASES;
    int rel;
    always_comb begin
      rel = int'(phaseCnt) - OFF;
      if (rel < 0) rel = rel + PERIOD;
      phaseHigh[i] = strobe.shiftRun && (rel < HIGH_CYCLES);
    end
  end

  assign imgClk = phaseHigh;
  assign stgClk = phaseHigh;

  always_ff @(posedge clk) begin
    if (!rstN)              crCnt <= '0;
    else if (strobe.crLoad) crCnt <= CR_W'(CR_CYCLES);
    else if (crCnt != '0)   crCnt <= crCnt - 1'b1;
  end

  assign crPulse  = (crCnt != '0);
  assign blkClamp = !strobe.shiftRun && (int'(lineIdx) >= BLK_FIRST)
                    && (int'(lineIdx) <= BLK_LAST);
endmodule

// File: rtl/frame_shift_seq.sv
module frame_shift_seq
  import fts_pkg::*;
#(
  parameter int PERIOD      = 48,
  parameter int HIGH_CYCLES = 30,
  parameter int SHIFT_LINES = 1048,
  parameter int FRAME_LINES = 1250,
  parameter int CR_CYCLES   = 45,
  parameter int BLK_FIRST   = 5,
  parameter int BLK_LAST    = 12,
  localparam int LINE_W     = $clog2(FRAME_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_W-1:0]     shutterLine,
  input  logic                  lineDone,
  output logic                  lineStart,
  output logic                  crPulse,
  output logic                  blkClamp,
  output logic [NUM_PHASES-1:0] imgClk,
  output logic [NUM_PHASES-1:0] stgClk
);
  seqStrobe_t        strobe;
  logic              shiftDone;
  logic              shiftBusy;
  logic [LINE_W-1:0] lineIdx;

  fts_ctrl #(.FRAME_LINES(FRAME_LINES), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .shiftDone(shiftDone), .lineDone(lineDone),
    .shutterLine(shutterLine), .strobe(strobe), .lineStart(lineStart),
    .lineIdx(lineIdx), .busy(shiftBusy)
  );

  fts_dp #(
    .PERIOD(PERIOD), .HIGH_CYCLES(HIGH_CYCLES), .SHIFT_LINES(SHIFT_LINES),
    .CR_CYCLES(CR_CYCLES), .BLK_FIRST(BLK_FIRST), .BLK_LAST(BLK_LAST),
    .LINE_W(LINE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIdx(lineIdx),
    .shiftDone(shiftDone), .crPulse(crPulse), .blkClamp(blkClamp),
    .imgClk(imgClk), .stgClk(stgClk)
  );
endmodule

// File: rtl/fts_chk.sv
module fts_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       lineStart,
  input logic       crPulse,
  input logic       blkClamp,
  input logic [3:0] imgClk,
  input logic [3:0] stgClk
);
  AST_NO_START_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !lineStart);                                 // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);                            // R5
  AST_CLK_IDLE_READOUT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (imgClk == 4'b0 && stgClk == 4'b0));        // R2
  AST_SHIFT_DRIVES_PHASES: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (imgClk != 4'b0));                           // R4
  AST_CR_NOT_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !crPulse);                                   // R8
  AST_CLAMP_NOT_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !blkClamp);                                  // R10
endmodule

bind frame_shift_seq fts_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(shiftBusy), .lineStart(lineStart),
  .crPulse(crPulse), .blkClamp(blkClamp), .imgClk(imgClk), .stgClk(stgClk)
);

// File: tb/frame_shift_seq_tb.sv
module frame_shift_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P     = 48;
  localparam int HI    = 30;
  localparam int S     = 3;
  localparam int FL    = 6;
  localparam int CR    = 5;
  localparam int BF    = 1;
  localparam int BL    = 2;
  localparam int HOLD  = 8;
  localparam int LW    = $clog2(FL);
  localparam int SHUT  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [LW-1:0] shutterLine = LW'(SHUT);
  logic          lineDone = 1'b0;
  logic          lineStart, crPulse, blkClamp;
  logic [3:0]    imgClk, stgClk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  frame_shift_seq #(
    .PERIOD(P), .HIGH_CYCLES(HI), .SHIFT_LINES(S), .FRAME_LINES(FL),
    .CR_CYCLES(CR), .BLK_FIRST(BF), .BLK_LAST(BL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .shutterLine(shutterLine), .lineDone(lineDone),
    .lineStart(lineStart), .crPulse(crPulse), .blkClamp(blkClamp),
    .imgClk(imgClk), .stgClk(stgClk)
  );

  function automatic logic [3:0] expPhases(input int c);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) begin
      int rel;
      rel = c - i * P / 4;
      if (rel < 0) rel = rel + P;
      v[i] = (rel < HI);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every lineStart must match the head of the expected queue (R3 R5)
  always @(negedge clk) begin
    if (rstN && lineStart) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected lineStart", 1'b0, cyc, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check("R5 lineStart cycle", cyc == e, cyc, e);
      end
    end
  end

  // driver: a full burst starting at the current negedge (transfer position 0)
  task automatic runShift();
    expQ.push_back(cyc + S * P);            // R3 first line start
    for (int c = 0; c < S * P; c++) begin
      logic [3:0] e;
      e = expPhases(c % P);
      check("R4 image phases", imgClk == e, imgClk, e);
      check("R2 storage equals image", stgClk == imgClk, stgClk, imgClk);
      lineDone = (c == 50);                 // R6 ignored during burst
      @(negedge clk);
    end
    lineDone = 1'b0;
    check("R2 clocks idle after burst", imgClk == 4'b0 && stgClk == 4'b0, imgClk, 0);
    check("R3 lineStart after burst", lineStart == 1'b1, lineStart, 1);
  endtask

  task automatic runLines(input int shut);
    for (int k = 0; k < FL; k++) begin
      int crSeen;
      logic eb;
      eb = (k >= BF) && (k <= BL);
      check("R10 clamp flag", blkClamp == eb, blkClamp, eb);
      crSeen = 0;
      for (int d = 0; d < HOLD; d++) begin
        if (crPulse) crSeen++;
        @(negedge clk);
      end
      check("R10 clamp held to line end", blkClamp == eb, blkClamp, eb);
      if (shut != 0 && k == shut)
        check("R8 charge-reset length", crSeen == CR, crSeen, CR);
      else
        check("R9 no charge-reset", crSeen == 0, crSeen, 0);
      lineDone = 1'b1;
      if (k != FL - 1) expQ.push_back(cyc + 1);
      @(negedge clk);
      lineDone = 1'b0;
      if (k == FL - 1) begin
        check("R7 burst restarts", imgClk == expPhases(0), imgClk, expPhases(0));
        check("R7 no lineStart at frame end", lineStart == 1'b0, lineStart, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 lineStart low", lineStart == 1'b0, lineStart, 0);
    check("R1 crPulse low", crPulse == 1'b0, crPulse, 0);
    check("R1 blkClamp low", blkClamp == 1'b0, blkClamp, 0);
    runShift();
    runLines(SHUT);
    shutterLine = '0;
    runShift();
    runLines(0);
    check("R5 all line starts seen", expQ.size() == 0, expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule